// File: doc/BRIEF.md
# Counting Membership Filter with Sticky Saturation

The block answers, in one operation, whether an N-bit key may belong to a set that is kept in step with a small associative memory. Each key is spread over a register bit vector by several fixed multiplicative hash lanes. A parallel array of narrow counters records how many stored keys land on each slot. A slot's presence bit is set while its counter is non-zero and is cleared when the counter returns to zero. Because of this, keys can be removed as well as added. The filter never reports a stored key as absent. It can report a key that was never stored as present.

Commands arrive on a valid/ready interface and carry a 2-bit operation code and a key. Every command runs as a fixed two-cycle read-modify-write: the key is latched, and the counters are updated on the next edge. While an update is in flight, ready is held low, so a query never sees a half-applied change. Every command returns a one-cycle result with a hit bit and an underflow bit. To replace an entry in the shadowed memory, the owner issues a delete of the old key followed by an insert of the new one.

Top module: `bloom_count_filter`

## Requirements
- R1: After reset, every counter and every presence bit is zero. `cmd_ready_o` is 1 and `res_valid_o` and `underflow_o` are 0, and a query of any key reports a miss.
- R2: A command is taken on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` is 0 for the following cycle only. `res_valid_o` is 1 for exactly the one cycle that follows the second rising edge after acceptance.
- R3: Hash lane i, for i from 0 to NUM_HASH-1, takes C_i as the low KEY_W bits of 64'h9E3779B97F4A7C15 * (2*i+1). It forms P = (key * C_i) mod 2^KEY_W, and its index is the top IDX_W bits of P.
- R4: Operation codes are 2'b00 query, 2'b01 insert, 2'b10 delete, and 2'b11 acting as a query. For every command, `res_hit_o` is 1 only when all addressed presence bits were 1 before that command. A query changes no state.
- R5: An insert sets every addressed presence bit. It adds one to each addressed counter below its maximum of 2^CNT_W-1.
- R6: A delete subtracts one from each addressed counter that is neither zero nor at maximum. A counter that reaches zero clears its presence bit, so the key then reads as a miss unless another key still covers that slot.
- R7: A delete that addresses a counter already at zero leaves that counter unchanged. It still updates the key's other counters and drives `underflow_o` to 1 in its result cycle. `underflow_o` is 0 in every other cycle.
- R8: A counter at its maximum is never incremented or decremented again, so a saturated key keeps reading as a hit after any number of deletes.
- R9: When two or more lanes give the same index for one key, that counter changes by one only for the operation. Two inserts then two deletes of such a key leave it reading as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Filter can accept a command |
| cmd_op_i | input | 2 | Operation code (R4) |
| cmd_key_i | input | KEY_W | Key to hash |
| res_valid_o | output | 1 | Result pulse |
| res_hit_o | output | 1 | All addressed presence bits were set before the command |
| underflow_o | output | 1 | Delete touched a zero counter |

## Verification
A counter that is wrong in either direction shows up at the ports as an unexpected hit or miss on the next query of any key that maps to that slot. That query result appears two cycles after the query is accepted. Slots that drift low also show up as an early or unexpected underflow on a later delete. Stuck saturation or double counting of repeated indices stays hidden until the matching deletes have been issued. The bench therefore drives insert/delete sequences that should drain each slot, and it queries the key after every step.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic [1:0] {
    OP_QUERY  = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_ALTQ   = 2'b11
  } cbf_op_e;

  // odd multiplier for hash lane
  function automatic logic [63:0] lane_mult(int unsigned lane);
    return 64'h9E3779B97F4A7C15 * (64'(lane) * 64'd2 + 64'd1);
  endfunction
endpackage

// File: rtl/cbf_hash_lane.sv
module cbf_hash_lane #(
  parameter int unsigned KEY_W = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned LANE  = 0
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [63:0]      MULT_FULL = cbf_pkg::lane_mult(LANE);
  localparam logic [KEY_W-1:0] MULT      = MULT_FULL[KEY_W-1:0];

  logic [KEY_W-1:0] prod;
  assign prod  = key_i * MULT;
  assign idx_o = prod[KEY_W-1 -: IDX_W];
endmodule

// File: rtl/cbf_first_mask.sv
module cbf_first_mask #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned NUM_HASH = 3
) (
  input  logic [NUM_HASH-1:0][IDX_W-1:0] idx_i,
  output logic [NUM_HASH-1:0]            first_o
);
  // lane is owner of its slot unless a lower lane hit the same slot
  always_comb begin
    for (int j = 0; j < NUM_HASH; j++) begin
      first_o[j] = 1'b1;
      for (int l = 0; l < j; l++) begin
        if (idx_i[l] == idx_i[j]) first_o[j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cbf_store.sv
module cbf_store #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned NUM_HASH = 3,
  parameter int unsigned CNT_W    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           upd_en_i,
  input  logic                           ins_i,
  input  logic                           del_i,
  input  logic [NUM_HASH-1:0][IDX_W-1:0] idx_i,
  input  logic [NUM_HASH-1:0]            first_i,
  output logic                           hit_o,
  output logic                           uflow_o,
  output logic [(1<<IDX_W)-1:0]          bits_o,
  output logic [(1<<IDX_W)-1:0][CNT_W-1:0] cnt_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DEPTH-1:0]            bits_q;
  logic [DEPTH-1:0][CNT_W-1:0] cnt_q;

  logic [NUM_HASH-1:0][CNT_W-1:0] cur_cnt, nxt_cnt;
  logic [NUM_HASH-1:0]            nxt_bit, lane_we;

  always_comb begin
    hit_o   = 1'b1;
    uflow_o = 1'b0;
    for (int j = 0; j < NUM_HASH; j++) begin
      cur_cnt[j] = cnt_q[idx_i[j]];
      nxt_cnt[j] = cur_cnt[j];
      nxt_bit[j] = bits_q[idx_i[j]];
      hit_o      = hit_o & bits_q[idx_i[j]];
      lane_we[j] = upd_en_i & first_i[j] & (ins_i | del_i);
      if (ins_i) begin
        nxt_bit[j] = 1'b1;
        if (cur_cnt[j] != CNT_MAX) nxt_cnt[j] = cur_cnt[j] + CNT_W'(1);
      end else if (del_i) begin
        if (cur_cnt[j] == '0) begin
          if (first_i[j]) uflow_o = 1'b1;
        end else if (cur_cnt[j] != CNT_MAX) begin
          nxt_cnt[j] = cur_cnt[j] - CNT_W'(1);
          nxt_bit[j] = (cur_cnt[j] != CNT_W'(1));
        end
      end
    end
  end

  // owning lanes have distinct slots, so writes never collide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else begin
      for (int j = 0; j < NUM_HASH; j++) begin
        if (lane_we[j]) begin
          cnt_q[idx_i[j]]  <= nxt_cnt[j];
          bits_q[idx_i[j]] <= nxt_bit[j];
        end
      end
    end
  end

  assign bits_o = bits_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/bloom_count_filter.sv
module bloom_count_filter #(
  parameter int unsigned KEY_W    = 32,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned NUM_HASH = 3,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [KEY_W-1:0] cmd_key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic             underflow_o
);
  import cbf_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             busy_q;
  logic [KEY_W-1:0] key_q;
  cbf_op_e          op_q;
  logic             res_valid_q, res_hit_q, uflow_q;

  logic [NUM_HASH-1:0][IDX_W-1:0] lane_idx;
  logic [NUM_HASH-1:0]            lane_first;
  logic                           st_hit, st_uflow;
  logic [DEPTH-1:0]               bits_w;
  logic [DEPTH-1:0][CNT_W-1:0]    cnt_w;

  for (genvar g = 0; g < NUM_HASH; g++) begin : g_lane
    cbf_hash_lane #(
      .KEY_W(KEY_W), .IDX_W(IDX_W), .LANE(g)
    ) u_hash (
      .key_i(key_q),
      .idx_o(lane_idx[g])
    );
  end

  cbf_first_mask #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_mask (
    .idx_i  (lane_idx),
    .first_o(lane_first)
  );

  cbf_store #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .CNT_W(CNT_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_en_i(busy_q),
    .ins_i   (op_q == OP_INSERT),
    .del_i   (op_q == OP_DELETE),
    .idx_i   (lane_idx),
    .first_i (lane_first),
    .hit_o   (st_hit),
    .uflow_o (st_uflow),
    .bits_o  (bits_w),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      key_q       <= '0;
      op_q        <= OP_QUERY;
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      uflow_q     <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      uflow_q     <= 1'b0;
      if (busy_q) begin
        busy_q      <= 1'b0;
        res_valid_q <= 1'b1;
        res_hit_q   <= st_hit;
        uflow_q     <= st_uflow;
      end else if (cmd_valid_i) begin
        busy_q <= 1'b1;
        key_q  <= cmd_key_i;
        op_q   <= cbf_op_e'(cmd_op_i);
      end
    end
  end

  assign cmd_ready_o = ~busy_q;
  assign res_valid_o = res_valid_q;
  assign res_hit_o   = res_hit_q;
  assign underflow_o = uflow_q;
endmodule

// File: rtl/cbf_checker.sv
module cbf_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CNT_W = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cmd_valid_i,
  input logic                           cmd_ready_o,
  input logic [1:0]                     cmd_op_i,
  input logic                           res_valid_o,
  input logic                           underflow_o,
  input logic [(1<<IDX_W)-1:0]          bits_i,
  input logic [(1<<IDX_W)-1:0][CNT_W-1:0] cnt_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic bit_mism;
  always_comb begin
    bit_mism = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (bits_i[i] != (cnt_i[i] != '0)) bit_mism = 1'b1;
  end

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  a_r2_ready_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |=> cmd_ready_o);
  a_r2_result_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |-> ##2 res_valid_o);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  a_r7_underflow_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (res_valid_o && $past(cmd_valid_i && cmd_ready_o && cmd_op_i == 2'b10, 2)));
  a_r6_bit_tracks_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_mism);

  for (genvar g = 0; g < DEPTH; g++) begin : g_sat
    a_r8_sat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[g] == CNT_MAX) |=> (cnt_i[g] == CNT_MAX));
  end
endmodule

bind bloom_count_filter cbf_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_op_i   (cmd_op_i),
  .res_valid_o(res_valid_o),
  .underflow_o(underflow_o),
  .bits_i     (bits_w),
  .cnt_i      (cnt_w)
);

// File: tb/bloom_count_filter_tb_top.sv
`timescale 1ns/1ps
module bloom_count_filter_tb_top;
  localparam int KEY_W = 32, IDX_W = 8, NH = 3, CMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [KEY_W-1:0] cmd_key = '0;
  logic cmd_ready, res_valid, res_hit, uflow;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int mcnt[1<<IDX_W];

  always #10 clk = ~clk;

  bloom_count_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_key_i(cmd_key), .res_valid_o(res_valid),
    .res_hit_o(res_hit), .underflow_o(uflow)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3 hash formula
  function automatic int hidx(int lane, logic [31:0] key);
    logic [63:0] c;
    logic [31:0] p;
    c = 64'h9E3779B97F4A7C15 * 64'(2 * lane + 1);
    p = key * c[31:0];
    return int'(p[31:24]);
  endfunction

  task automatic run_op(int op, logic [31:0] key, string req);
    int li[NH];
    bit uniq[NH];
    int e_hit, e_uf;
    for (int j = 0; j < NH; j++) begin
      li[j] = hidx(j, key);
      uniq[j] = 1;
      for (int l = 0; l < j; l++) if (li[l] == li[j]) uniq[j] = 0;
    end
    e_hit = 1; e_uf = 0;
    for (int j = 0; j < NH; j++) if (mcnt[li[j]] == 0) e_hit = 0;
    for (int j = 0; j < NH; j++) begin
      if (!uniq[j]) continue;
      if (op == 1) begin
        if (mcnt[li[j]] < CMAX) mcnt[li[j]]++;
      end else if (op == 2) begin
        if (mcnt[li[j]] == 0) e_uf = 1;
        else if (mcnt[li[j]] != CMAX) mcnt[li[j]]--;
      end
    end
    @(negedge clk);
    chk("R2", "ready idle", int'(cmd_ready), 1);
    chk("R2", "no result idle", int'(res_valid), 0);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_key = key;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", "ready busy", int'(cmd_ready), 0);
    chk("R2", "no result busy", int'(res_valid), 0);
    @(negedge clk);
    chk("R2", "result valid", int'(res_valid), 1);
    chk("R2", "ready back", int'(cmd_ready), 1);
    chk(req, "hit", int'(res_hit), e_hit);
    chk("R7", "underflow", int'(uflow), e_uf);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ka, kb, ks, kd;
    logic [31:0] pool[8];
    for (int i = 0; i < (1 << IDX_W); i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", int'(cmd_ready), 1);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
    chk("R1", "underflow after reset", int'(uflow), 0);

    ka = 32'h1234_5678; kb = 32'hCAFE_0001; ks = 32'h0BAD_F00D;
    run_op(0, ka, "R1");
    run_op(0, kb, "R1");
    run_op(1, ka, "R5");
    run_op(0, ka, "R4");
    run_op(1, kb, "R5");
    run_op(0, kb, "R4");
    run_op(2, ka, "R6");
    run_op(0, ka, "R6");
    run_op(0, kb, "R6");
    run_op(2, ka, "R7");
    run_op(3, kb, "R4");
    run_op(0, kb, "R4");
    run_op(3, ka, "R4");
    run_op(0, ka, "R4");

    for (int i = 0; i < 4; i++) run_op(1, ks, "R8");
    for (int i = 0; i < 5; i++) run_op(2, ks, "R8");
    run_op(0, ks, "R8");

    kd = 32'h0000_1000;
    while (!(hidx(0, kd) == hidx(1, kd) && hidx(2, kd) != hidx(0, kd))) kd++;
    run_op(1, kd, "R9");
    run_op(1, kd, "R9");
    run_op(0, kd, "R9");
    run_op(2, kd, "R9");
    run_op(2, kd, "R9");
    run_op(0, kd, "R9");
    run_op(2, kd, "R9");

    for (int i = 0; i < 8; i++) pool[i] = 32'h5000_0000 + 32'(i) * 32'h0101_3377;
    for (int n = 0; n < 80; n++) begin
      int o;
      o = $urandom_range(0, 2);
      run_op(o, pool[$urandom_range(0, 7)], "R4");
    end
    for (int i = 0; i < 8; i++) run_op(0, pool[i], "R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule